// File: doc/BRIEF.md
# Sector Disk Controller on a RAM Image

This block gives a processor the register view of a classic single-density floppy controller. Behind it sits a fixed disk image held in memory instead of a drive. Software writes a track number, a sector number and a command. The controller then moves one 128-byte sector, one byte at a time, between its data register and the image. A status register tells the processor when the controller is busy, when a byte is waiting or wanted, and when the requested sector does not exist.

The image holds 81920 bytes: one side of a disk with 40 tracks of 16 sectors of 128 bytes each. Sectors are numbered from 1. The memory is outside the block and is reached through an address port, a write strobe and two data buses. The read port has one cycle of latency. The image is filled before the machine starts. At run time it changes only when a sector is written. Four commands are supported: a restore to track 0, a seek, a sector read and a sector write. Drive timing, index pulses and formatting are not modelled.

Top module: `sector_disk_ctrl`

## Requirements
- R1: After reset the status, track, sector and data registers all read 0.
- R2: `reg_sel` picks a register. 0 is the command register on writes and the status register on reads, 1 is track, 2 is sector and 3 is data. In the status byte, bit 0 is busy, bit 1 is data-request and bit 4 is record-not-found; all other bits read 0.
- R3: The command byte is decoded on its upper nibble. Restore (0x0) sets the track register to 0. Seek (0x1) copies the data register into the track register. Neither command sets busy.
- R4: A read-sector command (0x8) with a valid track and sector sets busy. For each byte index i from 0 to 127, it places the image byte at ((track*16 + sector-1)*128 + i) in the data register, and only then raises data-request.
- R5: A read strobe on the data register while data-request is set clears data-request. The next byte follows. Busy clears on the read of the 128th byte.
- R6: A write-sector command (0xA) with a valid track and sector sets busy and raises data-request. Each data-register write clears data-request, and the byte is then stored at the address given in R4. Busy clears after the 128th byte is stored, and later reads of that sector return the new bytes.
- R7: A read or write command with sector 0, a sector above 16, or a track of 40 or more sets record-not-found. It does not set busy and does not raise data-request, and it leaves the image unchanged.
- R8: While busy is set, writes to the command, track and sector registers are ignored. Data-register writes are also ignored during a sector read.
- R9: Command bytes with an upper nibble other than 0x0, 0x1, 0x8 or 0xA are ignored: the registers and status do not change.
- R10: Every accepted command clears a record-not-found left by an earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select from the processor |
| rd_stb | input | 1 | Register read strobe, one cycle |
| wr_stb | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Data bus from the processor |
| rd_data | output | 8 | Data bus to the processor, selected register |
| img_addr | output | 17 | Byte address into the disk image |
| img_we | output | 1 | Image write strobe |
| img_wdata | output | 8 | Byte to store into the image |
| img_rdata | input | 8 | Image byte, one cycle after the address |

## Verification
Some properties are checked on every cycle by the assertions:
- data-request never appears without busy;
- a data read acknowledged during a transfer drops data-request on the next cycle;
- the end of a sector returns the controller to idle;
- a rejected command leaves busy clear and record-not-found set;
- the track and sector registers do not move while busy;
- the image is written only during a transfer.

Only the bench scenarios can show the rest:
- that the right byte comes from the right address, which the bench checks against its own model of the image;
- that written sectors read back correctly;
- that an out-of-range write leaves the whole image untouched;
- that stray register writes during a transfer leave the data stream intact.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam logic [1:0] SEL_CMD    = 2'd0;
  localparam logic [1:0] SEL_TRACK  = 2'd1;
  localparam logic [1:0] SEL_SECTOR = 2'd2;
  localparam logic [1:0] SEL_DATA   = 2'd3;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DRQ_BIT  = 1;
  localparam int STAT_RNF_BIT  = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RESTORE,
    OP_SEEK,
    OP_READ,
    OP_WRITE
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FETCH,
    ST_RD_LOAD,
    ST_RD_WAIT,
    ST_WR_WAIT,
    ST_WR_STORE
  } xfer_state_t;

  function automatic op_t decode_op(input logic [7:0] cmd);
    case (cmd[7:4])
      4'h0:    return OP_RESTORE;
      4'h1:    return OP_SEEK;
      4'h8:    return OP_READ;
      4'hA:    return OP_WRITE;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic int unsigned image_offset(
    input int unsigned trk, input int unsigned sec, input int unsigned idx,
    input int unsigned spt, input int unsigned bps);
    return (trk * spt + (sec - 1)) * bps + idx;
  endfunction

  function automatic bit sector_in_range(
    input int unsigned trk, input int unsigned sec,
    input int unsigned tracks, input int unsigned spt);
    return (trk < tracks) && (sec >= 1) && (sec <= spt);
  endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
#(
  parameter int TRACKS = 40,
  parameter int SPT    = 16
) (
  input  logic [7:0] cmd_byte,
  input  logic [7:0] track_q,
  input  logic [7:0] sector_q,
  input  logic       cmd_wr,
  input  logic       busy,
  output op_t        op,
  output logic       cmd_accept,
  output logic       start_rd,
  output logic       start_wr,
  output logic       reject
);
  logic geom_ok;
  logic is_xfer;

  always_comb begin
    op         = decode_op(cmd_byte);
    geom_ok    = sector_in_range(32'(track_q), 32'(sector_q), TRACKS, SPT);
    cmd_accept = cmd_wr && !busy && (op != OP_NONE);
    is_xfer    = (op == OP_READ) || (op == OP_WRITE);
    start_rd   = cmd_accept && (op == OP_READ)  && geom_ok;
    start_wr   = cmd_accept && (op == OP_WRITE) && geom_ok;
    reject     = cmd_accept && is_xfer && !geom_ok;
  end
endmodule

// File: rtl/sdc_addr_gen.sv
module sdc_addr_gen
  import sdc_pkg::*;
#(
  parameter int SPT    = 16,
  parameter int BPS    = 128,
  parameter int ADDR_W = 17,
  parameter int IDX_W  = 7
) (
  input  logic [7:0]        track_q,
  input  logic [7:0]        sector_q,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr = ADDR_W'(image_offset(32'(track_q), 32'(sector_q), 32'(idx), SPT, BPS));
  end
endmodule

// File: rtl/sdc_xfer_fsm.sv
module sdc_xfer_fsm
  import sdc_pkg::*;
#(
  parameter int BPS   = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_accept,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic             reject,
  input  logic             cpu_data_rd,
  input  logic             cpu_data_wr,
  output logic             busy,
  output logic             drq,
  output logic             rnf,
  output logic             load_byte,
  output logic             store_byte,
  output logic             data_wr_ok,
  output logic             byte_done,
  output logic             sector_done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BPS - 1);

  xfer_state_t state;
  logic        last_byte;
  logic        rd_ack;

  always_comb begin
    busy        = (state != ST_IDLE);
    last_byte   = (idx == LAST_IDX);
    load_byte   = (state == ST_RD_LOAD);
    store_byte  = (state == ST_WR_STORE);
    data_wr_ok  = (state == ST_IDLE) || (state == ST_WR_WAIT);
    rd_ack      = (state == ST_RD_WAIT) && cpu_data_rd;
    byte_done   = rd_ack || store_byte;
    sector_done = byte_done && last_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      drq   <= 1'b0;
      rnf   <= 1'b0;
    end else begin
      if (reject)          rnf <= 1'b1;
      else if (cmd_accept) rnf <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_rd) begin
            idx   <= '0;
            state <= ST_RD_FETCH;
          end else if (start_wr) begin
            idx   <= '0;
            drq   <= 1'b1;
            state <= ST_WR_WAIT;
          end
        end
        ST_RD_FETCH: state <= ST_RD_LOAD;
        ST_RD_LOAD: begin
          drq   <= 1'b1;
          state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (cpu_data_rd) begin
            drq <= 1'b0;
            if (last_byte) state <= ST_IDLE;
            else begin
              idx   <= idx + 1'b1;
              state <= ST_RD_FETCH;
            end
          end
        end
        ST_WR_WAIT: begin
          if (cpu_data_wr) begin
            drq   <= 1'b0;
            state <= ST_WR_STORE;
          end
        end
        ST_WR_STORE: begin
          if (last_byte) state <= ST_IDLE;
          else begin
            idx   <= idx + 1'b1;
            drq   <= 1'b1;
            state <= ST_WR_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) drq |-> busy); // R4
  AST_READ_ACK_DROPS_DRQ: assert property (@(posedge clk) disable iff (!rst_n) rd_ack |=> !drq); // R5
  AST_SECTOR_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n) sector_done |=> !busy); // R5
  AST_REJECT_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n) reject |=> (!busy && !drq && rnf)); // R7
endmodule

// File: rtl/sector_disk_ctrl.sv
module sector_disk_ctrl
  import sdc_pkg::*;
#(
  parameter int TRACKS = 40,
  parameter int SPT    = 16,
  parameter int BPS    = 128,
  localparam int ADDR_W = $clog2(TRACKS * SPT * BPS),
  localparam int IDX_W  = $clog2(BPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] img_addr,
  output logic              img_we,
  output logic [7:0]        img_wdata,
  input  logic [7:0]        img_rdata
);
  logic [7:0] track_q, sector_q, data_q, status;
  op_t        op;
  logic       cmd_wr, cmd_accept, start_rd, start_wr, reject;
  logic       cpu_data_rd, cpu_data_wr;
  logic       busy, drq, rnf;
  logic       load_byte, store_byte, data_wr_ok, byte_done, sector_done;
  logic [IDX_W-1:0] idx;

  assign cmd_wr      = wr_stb && (reg_sel == SEL_CMD);
  assign cpu_data_rd = rd_stb && (reg_sel == SEL_DATA);
  assign cpu_data_wr = wr_stb && (reg_sel == SEL_DATA);

  sdc_cmd_decode #(.TRACKS(TRACKS), .SPT(SPT)) u_dec (
    .cmd_byte(wr_data), .track_q(track_q), .sector_q(sector_q),
    .cmd_wr(cmd_wr), .busy(busy), .op(op), .cmd_accept(cmd_accept),
    .start_rd(start_rd), .start_wr(start_wr), .reject(reject)
  );

  sdc_xfer_fsm #(.BPS(BPS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .start_rd(start_rd),
    .start_wr(start_wr), .reject(reject), .cpu_data_rd(cpu_data_rd),
    .cpu_data_wr(cpu_data_wr), .busy(busy), .drq(drq), .rnf(rnf),
    .load_byte(load_byte), .store_byte(store_byte), .data_wr_ok(data_wr_ok),
    .byte_done(byte_done), .sector_done(sector_done), .idx(idx)
  );

  sdc_addr_gen #(.SPT(SPT), .BPS(BPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .track_q(track_q), .sector_q(sector_q), .idx(idx), .addr(img_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q  <= '0;
      sector_q <= '0;
      data_q   <= '0;
    end else begin
      if (cmd_accept && op == OP_RESTORE)   track_q <= '0;
      else if (cmd_accept && op == OP_SEEK) track_q <= data_q;
      else if (wr_stb && reg_sel == SEL_TRACK && !busy) track_q <= wr_data;

      if (wr_stb && reg_sel == SEL_SECTOR && !busy) sector_q <= wr_data;

      if (load_byte)                       data_q <= img_rdata;
      else if (cpu_data_wr && data_wr_ok)  data_q <= wr_data;
    end
  end

  always_comb begin
    status = '0;
    status[STAT_BUSY_BIT] = busy;
    status[STAT_DRQ_BIT]  = drq;
    status[STAT_RNF_BIT]  = rnf;
    case (reg_sel)
      SEL_CMD:    rd_data = status;
      SEL_TRACK:  rd_data = track_q;
      SEL_SECTOR: rd_data = sector_q;
      default:    rd_data = data_q;
    endcase
    img_we    = store_byte;
    img_wdata = data_q;
  end

  AST_TRACK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(track_q)); // R8
  AST_SECTOR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(sector_q)); // R8
  AST_WE_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n) img_we |-> (busy && !drq)); // R6
endmodule

// File: tb/sector_disk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sector_disk_ctrl_tb_top;
  localparam int IMG = 81920;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic rd_stb = 0, wr_stb = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [16:0] img_addr;
  logic img_we;
  logic [7:0] img_wdata;
  logic [7:0] img_rdata = 0;

  logic [7:0] mem [0:IMG-1];
  logic [7:0] ref_img [0:IMG-1];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sector_disk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .img_addr(img_addr), .img_we(img_we),
    .img_wdata(img_wdata), .img_rdata(img_rdata)
  );

  always @(posedge clk) begin
    if (img_we) mem[img_addr] <= img_wdata;
    img_rdata <= mem[img_addr];
  end

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 13) ^ (a >> 7) ^ 32'h5A);
  endfunction

  function automatic int byte_pos(input int t, input int s, input int b);
    return t * 2048 + s * 128 - 128 + b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); reg_sel = sel; wr_data = v; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk); reg_sel = sel; rd_stb = 1; #1 v = rd_data;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic wait_drq(output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int k = 0; k < 40 && !ok; k++) begin
      rd_reg(2'd0, s);
      if (s[1]) ok = 1;
    end
  endtask

  task automatic read_sector(input int t, input int s, input string req);
    logic [7:0] v, st;
    bit ok;
    int bad = 0, first_act = 0, first_exp = 0;
    wr_reg(2'd1, 8'(t)); wr_reg(2'd2, 8'(s)); wr_reg(2'd0, 8'h80);
    for (int b = 0; b < 128; b++) begin
      wait_drq(ok);
      rd_reg(2'd3, v);
      if (!ok || v !== ref_img[byte_pos(t, s, b)]) begin
        if (bad == 0) begin first_act = v; first_exp = ref_img[byte_pos(t, s, b)]; end
        bad++;
      end
    end
    check(bad == 0, req, first_act, first_exp);
    rd_reg(2'd0, st);
    check(st == 8'h00, "R5 busy clear after 128th byte", st, 0);
  endtask

  task automatic write_sector(input int t, input int s, input int seed);
    logic [7:0] st;
    bit ok;
    int bad = 0;
    wr_reg(2'd1, 8'(t)); wr_reg(2'd2, 8'(s)); wr_reg(2'd0, 8'hA0);
    for (int b = 0; b < 128; b++) begin
      logic [7:0] v;
      v = 8'(seed * 31 + b * 5 + 1);
      wait_drq(ok);
      if (!ok) bad++;
      wr_reg(2'd3, v);
      ref_img[byte_pos(t, s, b)] = v;
    end
    check(bad == 0, "R6 drq per written byte", bad, 0);
    repeat (2) @(negedge clk);
    rd_reg(2'd0, st);
    check(st == 8'h00, "R6 busy clear after write", st, 0);
  endtask

  task automatic image_same(input string req);
    int diff = 0;
    for (int a = 0; a < IMG; a++) if (mem[a] !== ref_img[a]) diff++;
    check(diff == 0, req, diff, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, st;
    bit ok;
    for (int a = 0; a < IMG; a++) begin
      mem[a] = pattern(a);
      ref_img[a] = pattern(a);
    end
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      rd_reg(2'(r), v);
      check(v == 8'h00, "R1 reset value", v, 0);
    end

    // R2 register select
    wr_reg(2'd2, 8'h0B); wr_reg(2'd1, 8'h21);
    rd_reg(2'd2, v); check(v == 8'h0B, "R2 sector register", v, 8'h0B);
    rd_reg(2'd1, v); check(v == 8'h21, "R2 track register", v, 8'h21);

    // R3 restore and seek
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd1, v); check(v == 8'h00, "R3 restore", v, 0);
    wr_reg(2'd3, 8'h17); wr_reg(2'd0, 8'h13);
    rd_reg(2'd1, v); check(v == 8'h17, "R3 seek", v, 8'h17);
    rd_reg(2'd0, st); check(st == 8'h00, "R3 no busy", st, 0);

    // R9 unknown command
    wr_reg(2'd0, 8'h50);
    rd_reg(2'd1, v); check(v == 8'h17, "R9 unknown cmd track", v, 8'h17);
    rd_reg(2'd0, st); check(st == 8'h00, "R9 unknown cmd status", st, 0);

    // R4 R5 boundary sectors
    read_sector(0, 1, "R4 first sector data");
    read_sector(39, 16, "R4 last sector data");

    // R7 out of range
    wr_reg(2'd1, 8'd5); wr_reg(2'd2, 8'd0); wr_reg(2'd0, 8'h80);
    rd_reg(2'd0, st); check(st == 8'h10, "R7 sector 0", st, 8'h10);
    wr_reg(2'd0, 8'h60);
    rd_reg(2'd0, st); check(st == 8'h10, "R9 unknown cmd keeps rnf", st, 8'h10);
    wr_reg(2'd2, 8'd17); wr_reg(2'd0, 8'hA0);
    repeat (3) @(negedge clk);
    rd_reg(2'd0, st); check(st == 8'h10, "R7 sector 17 write", st, 8'h10);
    wr_reg(2'd1, 8'd40); wr_reg(2'd2, 8'd1); wr_reg(2'd0, 8'hA0);
    rd_reg(2'd0, st); check(st == 8'h10, "R7 track 40 write", st, 8'h10);
    image_same("R7 image untouched");

    // R10 accepted command clears rnf
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, st); check(st == 8'h00, "R10 rnf cleared", st, 0);

    // R6 write then read back
    write_sector(12, 7, 3);
    read_sector(12, 7, "R6 readback");
    write_sector(39, 16, 9);
    read_sector(39, 16, "R6 readback last sector");

    // R8 writes ignored while busy
    wr_reg(2'd1, 8'd3); wr_reg(2'd2, 8'd5); wr_reg(2'd0, 8'h80);
    wait_drq(ok);
    check(ok, "R4 drq raised", ok, 1);
    wr_reg(2'd1, 8'd9); wr_reg(2'd2, 8'd2); wr_reg(2'd0, 8'h00); wr_reg(2'd3, 8'hEE);
    rd_reg(2'd1, v); check(v == 8'd3, "R8 track held", v, 3);
    rd_reg(2'd2, v); check(v == 8'd5, "R8 sector held", v, 5);
    begin
      int bad = 0;
      for (int b = 0; b < 128; b++) begin
        if (b > 0) wait_drq(ok);
        rd_reg(2'd3, v);
        if (v !== ref_img[byte_pos(3, 5, b)]) bad++;
      end
      check(bad == 0, "R8 stream intact", bad, 0);
    end
    rd_reg(2'd0, st); check(st == 8'h00, "R5 idle after busy test", st, 0);

    // Random mix
    for (int n = 0; n < 14; n++) begin
      int t, s;
      t = $urandom_range(39, 0);
      s = $urandom_range(16, 1);
      if ($urandom_range(1, 0) == 1) write_sector(t, s, n + 20);
      read_sector(t, s, "R4 random sector");
    end
    image_same("R6 image matches model");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule